// File: doc/BRIEF.md
# Fault Freeze and Recovery Controller

This block supervises one checked functional unit inside a processor pipeline. The unit raises a concurrent error signal when its checker sees a mismatch. The controller turns that signal into a pipeline freeze in the same cycle, so the sequential state holds and the unit's combinational inputs stay constant. It then waits a programmable number of cycles to learn whether the fault is transient or permanent.

If the error goes away inside the window, the freeze drops and the pipeline carries on with no rollback. If the error is still present when the window ends, the controller takes sole control of the freeze line. It pulses a reconfiguration request to an external loader and holds the pipeline until the loader reports completion. It then steers the result multiplexer to the spare unit and records the new occupant's signature in a status word that software can read.

A watchdog limits how long the controller waits for completion. When it expires, a fatal flag is raised and the pipeline stays frozen until reset.

Top module: `fault_recovery_ctrl`

## Requirements
- R1: While no reconfiguration is in progress, `freeze` is high in the same cycle that `unit_err` is high, with no clock edge in between.
- R2: With `win_len` = N > 0, if `unit_err` is sampled high on N+1 consecutive rising edges, the last of those edges starts a reconfiguration. `reconf_start` is high for exactly the following clock cycle.
- R3: If `unit_err` falls before N+1 consecutive high samples, `freeze` goes low in the same cycle. No reconfiguration starts, and the permanent flag stays clear.
- R4: From the edge that starts a reconfiguration until release, `freeze` stays high whatever `unit_err` does. An error raised during this time starts no second request.
- R5: `freeze` stays high on the edge that samples `reconf_done` high. It goes low on the next edge, provided `unit_err` is then low.
- R6: The edge that samples `reconf_done` sets `spare_sel` to 1. The same edge changes the signature field `status[7:0]` from the reset value 0xA5 to 0x5A and sets the spare bit `status[10]`.
- R7: With `win_len` = 0, the first edge that samples `unit_err` high starts the reconfiguration.
- R8: The permanent-fault flag `status[8]` is set on the edge that starts a reconfiguration. It stays set until reset.
- R9: If `reconf_done` is not seen for TMO_CYCLES edges after the start, the fatal flag `status[9]` is set on the TMO_CYCLES-th edge. After that, `freeze` stays high, and a late `reconf_done` leaves `spare_sel` at 0. The flag holds until reset.
- R10: After reset, with `unit_err` low, `freeze`, `reconf_start` and `spare_sel` are 0, and `status` equals 0x0A5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| unit_err | input | 1 | Concurrent error from the checked unit |
| win_len | input | CNT_W | Persistence window N in cycles; 0 means decide at once |
| reconf_done | input | 1 | Completion indication from the external loader |
| freeze | output | 1 | Pipeline hold |
| reconf_start | output | 1 | One-cycle reconfiguration request |
| spare_sel | output | 1 | Result mux select: 1 picks the external spare unit |
| status | output | SIG_W+3 | {spare, fatal, permanent, signature} |

## Verification
The error input is driven with four patterns. A pulse that ends early in the window and one that ends exactly one sample short of the limit both show that a transient fault resumes with no request. An error held for the full N+1 samples shows the permanent path, including error toggling during the reload and the release timing after completion. A zero-length window separates the immediate decision from the counted one, and a reload that never completes exercises the fatal hold and confirms that a late completion has no effect.

// File: rtl/frc_pkg.sv
// Package: shared state encoding for the fault recovery controller.
// Assumes nothing beyond a two-bit state register.
package frc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_RECONF = 2'd2,
        ST_DONE   = 2'd3
    } frc_state_t;
endpackage

// File: rtl/frc_window_cnt.sv
// Persistence window counter.
// Loaded with 1 on the first error sample and advanced on each later sample.
// Reports when the count has reached the programmed limit.
// Assumes the limit stays stable while a window is open.
module frc_window_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             advance,
    input  logic [CNT_W-1:0] limit,
    output logic             at_limit,
    output logic             zero_len
);
    logic [CNT_W-1:0] cnt_q;

    // Count error samples inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (start)   cnt_q <= CNT_W'(1);
        else if (advance) cnt_q <= cnt_q + CNT_W'(1);
    end

    // Compare against the programmed window length.
    always_comb begin
        at_limit = (cnt_q == limit);
        zero_len = (limit == '0);
    end
endmodule

// File: rtl/frc_reconf_timer.sv
// Reconfiguration watchdog.
// Cleared when a request is issued and advanced on each edge spent waiting.
// Flags expiry on the TMO_CYCLES-th waiting edge.
// Assumes TMO_CYCLES >= 1.
module frc_reconf_timer #(
    parameter int TMO_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int TMO_W = $clog2(TMO_CYCLES + 1);
    logic [TMO_W-1:0] cnt_q;

    // Count waiting edges since the request.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clear) cnt_q <= '0;
        else if (run && !expired) cnt_q <= cnt_q + TMO_W'(1);
    end

    // Expiry is seen on the edge that would complete the budget.
    always_comb expired = run && (cnt_q == TMO_W'(TMO_CYCLES - 1));
endmodule

// File: rtl/frc_status.sv
// Status holder: signature of the current occupant, spare select,
// and the sticky permanent and fatal flags.
// Assumes swap and expiry never fire on the same edge; the sequencer guarantees this.
module frc_status #(
    parameter int             SIG_W     = 8,
    parameter logic [SIG_W-1:0] HOME_SIG  = 8'hA5,
    parameter logic [SIG_W-1:0] SPARE_SIG = 8'h5A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mark_perm,
    input  logic             swap,
    input  logic             mark_fatal,
    output logic             fatal,
    output logic             spare,
    output logic [SIG_W+2:0] word
);
    logic [SIG_W-1:0] sig_q;
    logic             perm_q;
    logic             fatal_q;
    logic             spare_q;

    // Record outcome of each recovery step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sig_q   <= HOME_SIG;
            perm_q  <= 1'b0;
            fatal_q <= 1'b0;
            spare_q <= 1'b0;
        end else begin
            if (mark_perm)  perm_q  <= 1'b1;
            if (mark_fatal) fatal_q <= 1'b1;
            if (swap) begin
                spare_q <= 1'b1;
                sig_q   <= SPARE_SIG;
            end
        end
    end

    // Assemble the readable word.
    always_comb begin
        word  = {spare_q, fatal_q, perm_q, sig_q};
        fatal = fatal_q;
        spare = spare_q;
    end
endmodule

// File: rtl/frc_seq.sv
// Recovery sequencer.
// Lets freeze follow the error while idle or waiting; owns it during reload.
// Issues the request pulse and detects completion.
// Assumes reconf_done is a level or pulse from the external loader.
module frc_seq
    import frc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic unit_err,
    input  logic win_at_limit,
    input  logic win_zero,
    input  logic reconf_done,
    input  logic fatal,
    output logic win_start,
    output logic win_advance,
    output logic go_reconf,
    output logic swap,
    output logic tmr_run,
    output logic freeze,
    output logic reconf_start
);
    frc_state_t state_q, state_d;

    // Next-state decision and control strobes.
    always_comb begin
        state_d     = state_q;
        win_start   = 1'b0;
        win_advance = 1'b0;
        go_reconf   = 1'b0;
        swap        = 1'b0;
        tmr_run     = 1'b0;
        unique case (state_q)
            ST_IDLE: if (unit_err) begin
                if (win_zero) begin
                    go_reconf = 1'b1;
                    state_d   = ST_RECONF;
                end else begin
                    win_start = 1'b1;
                    state_d   = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (!unit_err) begin
                    state_d = ST_IDLE;
                end else if (win_at_limit) begin
                    go_reconf = 1'b1;
                    state_d   = ST_RECONF;
                end else begin
                    win_advance = 1'b1;
                end
            end
            ST_RECONF: if (!fatal) begin
                if (reconf_done) begin
                    swap    = 1'b1;
                    state_d = ST_DONE;
                end else begin
                    tmr_run = 1'b1;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State and request pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            reconf_start <= 1'b0;
        end else begin
            state_q      <= state_d;
            reconf_start <= go_reconf;
        end
    end

    // Freeze follows the error until the controller takes the line.
    always_comb begin
        if (state_q == ST_IDLE || state_q == ST_WAIT) freeze = unit_err;
        else                                          freeze = 1'b1;
    end
endmodule

// File: rtl/fault_recovery_ctrl.sv
// Top level of the fault freeze and recovery controller.
// Connects the sequencer, the window counter, the watchdog and the status holder.
// Assumes unit_err and reconf_done are synchronous to clk.
module fault_recovery_ctrl #(
    parameter int               CNT_W      = 8,
    parameter int               TMO_CYCLES = 4096,
    parameter int               SIG_W      = 8,
    parameter logic [SIG_W-1:0] HOME_SIG   = 8'hA5,
    parameter logic [SIG_W-1:0] SPARE_SIG  = 8'h5A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             unit_err,
    input  logic [CNT_W-1:0] win_len,
    input  logic             reconf_done,
    output logic             freeze,
    output logic             reconf_start,
    output logic             spare_sel,
    output logic [SIG_W+2:0] status
);
    logic win_start, win_advance, win_at_limit, win_zero;
    logic go_reconf, swap, tmr_run, tmr_expired, fatal;

    frc_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .unit_err     (unit_err),
        .win_at_limit (win_at_limit),
        .win_zero     (win_zero),
        .reconf_done  (reconf_done),
        .fatal        (fatal),
        .win_start    (win_start),
        .win_advance  (win_advance),
        .go_reconf    (go_reconf),
        .swap         (swap),
        .tmr_run      (tmr_run),
        .freeze       (freeze),
        .reconf_start (reconf_start)
    );

    frc_window_cnt #(.CNT_W(CNT_W)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (win_start),
        .advance  (win_advance),
        .limit    (win_len),
        .at_limit (win_at_limit),
        .zero_len (win_zero)
    );

    frc_reconf_timer #(.TMO_CYCLES(TMO_CYCLES)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (go_reconf),
        .run     (tmr_run),
        .expired (tmr_expired)
    );

    frc_status #(
        .SIG_W     (SIG_W),
        .HOME_SIG  (HOME_SIG),
        .SPARE_SIG (SPARE_SIG)
    ) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .mark_perm  (go_reconf),
        .swap       (swap),
        .mark_fatal (tmr_expired),
        .fatal      (fatal),
        .spare      (spare_sel),
        .word       (status)
    );
endmodule

// File: rtl/frc_checker.sv
// Assertion checker for the fault recovery controller, bound to the top.
// Observes ports only.
module frc_checker #(
    parameter int SIG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             unit_err,
    input logic             freeze,
    input logic             reconf_start,
    input logic             spare_sel,
    input logic [SIG_W+2:0] status
);
    // R1: an error is never left unfrozen.
    p_err_freezes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        unit_err |-> freeze);
    // R2: the request lasts a single cycle.
    p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reconf_start |=> !reconf_start);
    // R4: the pipeline is held while the request is out.
    p_hold_on_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reconf_start |-> freeze);
    // R8: the request coincides with the permanent flag.
    p_start_marks_perm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reconf_start |-> status[SIG_W]);
    // R8: the permanent flag is sticky.
    p_perm_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        status[SIG_W] |=> status[SIG_W]);
    // R9: the fatal flag is sticky and keeps the freeze.
    p_fatal_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        status[SIG_W+1] |=> status[SIG_W+1]);
    p_fatal_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        status[SIG_W+1] |-> freeze);
    // R6: the spare is only selected after a permanent fault.
    p_spare_after_perm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        spare_sel |-> (status[SIG_W] && status[SIG_W+2]));
endmodule

bind fault_recovery_ctrl frc_checker #(.SIG_W(SIG_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .unit_err     (unit_err),
    .freeze       (freeze),
    .reconf_start (reconf_start),
    .spare_sel    (spare_sel),
    .status       (status)
);

// File: tb/fault_recovery_ctrl_bench.sv
// Directed bench for the fault recovery controller.
// Drives inputs on the falling edge and samples shortly after it.
module fault_recovery_ctrl_bench;
    localparam int CNT_W = 8;
    localparam int TMO   = 20;
    localparam int SW    = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             unit_err = 1'b0;
    logic [CNT_W-1:0] win_len = '0;
    logic             reconf_done = 1'b0;
    logic             freeze, reconf_start, spare_sel;
    logic [SW+2:0]    status;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    fault_recovery_ctrl #(
        .CNT_W(CNT_W), .TMO_CYCLES(TMO), .SIG_W(SW),
        .HOME_SIG(8'hA5), .SPARE_SIG(8'h5A)
    ) u_fault_recovery_ctrl (
        .clk(clk), .rst_n(rst_n), .unit_err(unit_err), .win_len(win_len),
        .reconf_done(reconf_done), .freeze(freeze), .reconf_start(reconf_start),
        .spare_sel(spare_sel), .status(status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; unit_err = 1'b0; reconf_done = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    // R10: values right after reset.
    task automatic t_reset();
        do_reset();
        chk("R10 freeze", freeze, 0);
        chk("R10 start", reconf_start, 0);
        chk("R10 spare", spare_sel, 0);
        chk("R10 status", status, 32'h0A5);
    endtask

    // R1/R3: short transient pulse.
    task automatic t_transient();
        do_reset();
        win_len = 8'd4;
        @(negedge clk); unit_err = 1'b1; #1;
        chk("R1 freeze same cycle", freeze, 1);
        step(2);
        unit_err = 1'b0; #1;
        chk("R3 freeze drops", freeze, 0);
        step(6);
        chk("R3 no start", reconf_start, 0);
        chk("R3 no perm flag", status[8], 0);
    endtask

    // R3: error held one sample short of the limit.
    task automatic t_boundary_short();
        int starts = 0;
        do_reset();
        win_len = 8'd3;
        @(negedge clk); unit_err = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step(1);
            starts += int'(reconf_start);
        end
        unit_err = 1'b0; #1;
        chk("R3 boundary freeze low", freeze, 0);
        for (int i = 0; i < 4; i++) begin
            step(1);
            starts += int'(reconf_start);
        end
        chk("R3 boundary no start", starts, 0);
        chk("R3 boundary perm clear", status[8], 0);
    endtask

    // R2/R4/R5/R6/R8: permanent fault and successful swap.
    task automatic t_permanent();
        do_reset();
        win_len = 8'd3;
        @(negedge clk); unit_err = 1'b1;
        step(3);
        chk("R2 no start before window end", reconf_start, 0);
        step(1);
        chk("R2 start after N+1 samples", reconf_start, 1);
        chk("R8 perm flag set", status[8], 1);
        step(1);
        chk("R2 start one cycle", reconf_start, 0);
        unit_err = 1'b0; #1;
        chk("R4 freeze held with error low", freeze, 1);
        step(1);
        unit_err = 1'b1;
        step(3);
        chk("R4 no second request", reconf_start, 0);
        unit_err = 1'b0;
        reconf_done = 1'b1;
        step(1);
        reconf_done = 1'b0; #1;
        chk("R5 freeze on done edge", freeze, 1);
        chk("R6 spare select", spare_sel, 1);
        chk("R6 status after swap", status, 32'h55A);
        step(1);
        chk("R5 freeze released", freeze, 0);
        step(3);
        chk("R8 perm flag sticky", status[8], 1);
        chk("R6 spare held", spare_sel, 1);
    endtask

    // R7: zero-length window.
    task automatic t_zero_window();
        do_reset();
        win_len = 8'd0;
        @(negedge clk); unit_err = 1'b1; #1;
        chk("R7 no start yet", reconf_start, 0);
        step(1);
        chk("R7 immediate start", reconf_start, 1);
        unit_err = 1'b0;
    endtask

    // R9: reload never completes.
    task automatic t_timeout();
        do_reset();
        win_len = 8'd1;
        @(negedge clk); unit_err = 1'b1;
        step(2);
        chk("R9 start seen", reconf_start, 1);
        unit_err = 1'b0;
        step(TMO - 1);
        chk("R9 no fatal before budget", status[9], 0);
        step(1);
        chk("R9 fatal at budget", status[9], 1);
        reconf_done = 1'b1;
        step(2);
        reconf_done = 1'b0;
        step(2);
        chk("R9 freeze kept", freeze, 1);
        chk("R9 late done ignored", spare_sel, 0);
        chk("R9 fatal sticky", status[9], 1);
    endtask

    initial begin
        t_reset();
        t_transient();
        t_boundary_short();
        t_permanent();
        t_zero_window();
        t_timeout();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog run did not finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule